// File: doc/BRIEF.md
# Serial port interrupt cause and mask unit

This block raises the single interrupt request of a serial port. It watches the fill levels of the receive and transmit FIFOs, single-cycle strobes for line and transfer events, and the level of the DTR input. From these it builds a ten-bit event vector. A mask register selects which events may reach the interrupt line. A cause register shows the masked events in its low bits and the unmasked ones in its upper half. Software reads the cause register and writes the same value back to acknowledge the events that are held.

A trigger register holds the receive threshold, the transmit threshold and a flow-control level. The flow-control level is passed out to the flow-control logic. A receive-idle timeout is built as a three-state machine driven by a character-time tick. `TO_IDLE` is entered when the receive FIFO is empty. `TO_IDLE -> TO_WAIT` happens when the FIFO becomes non-empty. In `TO_WAIT` the machine counts ticks. `TO_WAIT -> TO_FIRED` happens on the tick that completes `TO_CHARS` character times with no push and no pop. `TO_WAIT -> TO_IDLE` happens when the FIFO empties. `TO_FIRED -> TO_IDLE` happens on a pop or when the FIFO empties.

Top module: `uirq_ctrl`

## Requirements
- R1: After reset the mask is 0, every held event is 0, the trigger register reads 0x00000001 (receive threshold 1, transmit threshold 0, flow level 0), the timeout is idle and `irq` is 0.
- R2: The event order is: 0 modem status change, 1 receive data available, 2 transmit data needed, 3 receive timeout, 4 line error, 5 transmit DMA done, 6 receive DMA done, 7 receive DMA timeout, 8 DTR rise, 9 DTR fall. The cause word places the raw event i at bit 16+i and the masked event i at bit i. Bits 10 to 15 and 26 to 31 read 0.
- R3: Event 1 is 1 exactly while `rx_level` is greater than or equal to the receive threshold.
- R4: Event 2 is 1 exactly while `tx_level` is less than or equal to the transmit threshold.
- R5: Events 0 and 4 to 9 are held. A strobe sets the event one clock later. The event then stays set until it is cleared.
- R6: A write to the cause register clears held event i when bit i or bit 16+i of the written data is 1. A bit written as 0 leaves its event set. A new strobe in the same cycle as the clear wins. Events 1, 2 and 3 are not affected by such writes.
- R7: A 0 to 1 change of `dtr` between consecutive clocks sets event 8. A 1 to 0 change sets event 9.
- R8: With the receive FIFO non-empty, event 3 becomes 1 one clock after the `TO_CHARS`-th `char_tick` that has no push or pop in between. A push or a pop restarts the count.
- R9: Event 3 drops one clock after a pop. If the FIFO empties before the count completes, event 3 does not fire.
- R10: `irq` is the OR of the masked events. A mask of 0 keeps `irq` at 0.
- R11: The trigger register holds the receive threshold in bits 4:0, the transmit threshold in bits 11:8 and the flow level in bits 20:16. All other bits read 0. The flow level also drives `flow_level`.
- R12: `reg_sel` picks the register: 0 mask, 1 cause, 2 trigger. Value 3 reads 0 and writes nothing. `reg_rdata` follows `reg_sel` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| rx_level | input | RX_LVL_W | Receive FIFO fill level |
| tx_level | input | TX_LVL_W | Transmit FIFO fill level |
| rx_push | input | 1 | A character entered the receive FIFO |
| rx_pop | input | 1 | A character was read from the receive FIFO |
| char_tick | input | 1 | One pulse per character time |
| modem_chg | input | 1 | Modem status change strobe |
| line_err | input | 1 | Receive line error strobe |
| tx_dma_done | input | 1 | Transmit DMA done strobe |
| rx_dma_done | input | 1 | Receive DMA done strobe |
| rx_dma_to | input | 1 | Receive DMA timeout strobe |
| dtr | input | 1 | DTR level |
| flow_level | output | 5 | Flow-control level from the trigger register |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the unit with a 6-bit receive level, a 5-bit transmit level and `TO_CHARS` set to 3. The 6-bit receive level lets the sweep cover every receive threshold from 0 to 31 against levels 0 to 32. The 5-bit transmit level lets every transmit threshold be compared against every level. The short timeout lets each state transition be driven tick by tick: firing, restart on push, clearing on pop and the empty-FIFO abort. A pattern of held and level events is then checked against all 1024 mask values.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
    localparam int N_EV = 10;
    localparam int EV_MODEM   = 0;
    localparam int EV_RX_AVL  = 1;
    localparam int EV_TX_NEED = 2;
    localparam int EV_RX_TO   = 3;
    localparam int EV_LINE    = 4;
    localparam int EV_TXDMA   = 5;
    localparam int EV_RXDMA   = 6;
    localparam int EV_RXDTO   = 7;
    localparam int EV_DTR_UP  = 8;
    localparam int EV_DTR_DN  = 9;
    // events held until cleared by software; the rest are live levels
    localparam logic [N_EV-1:0] HELD_EVENTS = 10'b11_1111_0001;
    localparam int RAW_BASE = 16;

    typedef enum logic [1:0] {
        SEL_MASK  = 2'd0,
        SEL_CAUSE = 2'd1,
        SEL_TRIG  = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        TO_IDLE  = 2'd0,
        TO_WAIT  = 2'd1,
        TO_FIRED = 2'd2
    } to_state_e;
endpackage

// File: rtl/uirq_timeout.sv
module uirq_timeout
    import uirq_pkg::*;
#(
    parameter int TO_CHARS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_nonempty,
    input  logic rx_push,
    input  logic rx_pop,
    input  logic char_tick,
    output logic fired
);
    localparam int CNT_W = $clog2(TO_CHARS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TO_CHARS - 1);

    to_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic activity;

    assign activity = rx_push | rx_pop;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TO_IDLE:  if (rx_nonempty) state_d = TO_WAIT;
            TO_WAIT: begin
                if (!rx_nonempty)
                    state_d = TO_IDLE;
                else if (!activity && char_tick && cnt_q == LAST)
                    state_d = TO_FIRED;
            end
            TO_FIRED: if (rx_pop || !rx_nonempty) state_d = TO_IDLE;
            default:  state_d = TO_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TO_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (state_q != TO_WAIT || activity)
            cnt_q <= '0;
        else if (char_tick)
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    always_comb begin
        fired = (state_q == TO_FIRED);
    end
endmodule

// File: rtl/uirq_evlatch.sv
module uirq_evlatch #(
    parameter int N = 10,
    parameter logic [N-1:0] HELD = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev_in,
    input  logic [N-1:0] clr,
    output logic [N-1:0] raw
);
    logic unused_clr;
    assign unused_clr = ^(clr & ~HELD);

    for (genvar i = 0; i < N; i++) begin : g_ev
        if (HELD[i]) begin : g_held
            logic q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)        q <= 1'b0;
                else if (ev_in[i]) q <= 1'b1;
                else if (clr[i])   q <= 1'b0;
            end
            assign raw[i] = q;
        end else begin : g_live
            assign raw[i] = ev_in[i];
        end
    end
endmodule

// File: rtl/uirq_ctrl.sv
module uirq_ctrl
    import uirq_pkg::*;
#(
    parameter int RX_LVL_W = 7,
    parameter int TX_LVL_W = 5,
    parameter int TO_CHARS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [1:0]          reg_sel,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic [RX_LVL_W-1:0] rx_level,
    input  logic [TX_LVL_W-1:0] tx_level,
    input  logic                rx_push,
    input  logic                rx_pop,
    input  logic                char_tick,
    input  logic                modem_chg,
    input  logic                line_err,
    input  logic                tx_dma_done,
    input  logic                rx_dma_done,
    input  logic                rx_dma_to,
    input  logic                dtr,
    output logic [4:0]          flow_level,
    output logic                irq
);
    localparam int RXT_W = 5;
    localparam int TXT_W = 4;

    reg_sel_e          sel;
    logic [N_EV-1:0]   mask_q, ev_in, clr, raw_vec;
    logic [RXT_W-1:0]  rx_thr_q;
    logic [TXT_W-1:0]  tx_thr_q;
    logic [4:0]        flow_q;
    logic              dtr_q, to_fired, rx_avail, tx_need;
    logic [31:0]       cause_word, trig_word;
    logic              unused_wbits;

    assign sel = reg_sel_e'(reg_sel);
    assign unused_wbits = ^{reg_wdata[31:26], reg_wdata[15:12]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q   <= '0;
            rx_thr_q <= RXT_W'(1);
            tx_thr_q <= '0;
            flow_q   <= '0;
            dtr_q    <= 1'b0;
        end else begin
            dtr_q <= dtr;
            if (reg_wr && sel == SEL_MASK)
                mask_q <= reg_wdata[N_EV-1:0];
            if (reg_wr && sel == SEL_TRIG) begin
                rx_thr_q <= reg_wdata[4:0];
                tx_thr_q <= reg_wdata[11:8];
                flow_q   <= reg_wdata[20:16];
            end
        end
    end

    assign rx_avail = {{(32-RX_LVL_W){1'b0}}, rx_level} >= {{(32-RXT_W){1'b0}}, rx_thr_q};
    assign tx_need  = {{(32-TX_LVL_W){1'b0}}, tx_level} <= {{(32-TXT_W){1'b0}}, tx_thr_q};

    uirq_timeout #(.TO_CHARS(TO_CHARS)) u_timeout (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_nonempty (|rx_level),
        .rx_push     (rx_push),
        .rx_pop      (rx_pop),
        .char_tick   (char_tick),
        .fired       (to_fired)
    );

    always_comb begin
        ev_in             = '0;
        ev_in[EV_MODEM]   = modem_chg;
        ev_in[EV_RX_AVL]  = rx_avail;
        ev_in[EV_TX_NEED] = tx_need;
        ev_in[EV_RX_TO]   = to_fired;
        ev_in[EV_LINE]    = line_err;
        ev_in[EV_TXDMA]   = tx_dma_done;
        ev_in[EV_RXDMA]   = rx_dma_done;
        ev_in[EV_RXDTO]   = rx_dma_to;
        ev_in[EV_DTR_UP]  = dtr & ~dtr_q;
        ev_in[EV_DTR_DN]  = ~dtr & dtr_q;
    end

    assign clr = (reg_wr && sel == SEL_CAUSE)
               ? (reg_wdata[N_EV-1:0] | reg_wdata[RAW_BASE +: N_EV]) : '0;

    uirq_evlatch #(.N(N_EV), .HELD(HELD_EVENTS)) u_events (
        .clk   (clk),
        .rst_n (rst_n),
        .ev_in (ev_in),
        .clr   (clr),
        .raw   (raw_vec)
    );

    assign cause_word = {6'b0, raw_vec, 6'b0, raw_vec & mask_q};
    assign trig_word  = {11'b0, flow_q, 4'b0, tx_thr_q, 3'b0, rx_thr_q};

    always_comb begin
        unique case (sel)
            SEL_MASK:  reg_rdata = {{(32-N_EV){1'b0}}, mask_q};
            SEL_CAUSE: reg_rdata = cause_word;
            SEL_TRIG:  reg_rdata = trig_word;
            SEL_NONE:  reg_rdata = '0;
            default:   reg_rdata = '0;
        endcase
    end

    assign flow_level = flow_q;
    assign irq        = |(raw_vec & mask_q);
endmodule

// File: rtl/uirq_ctrl_chk.sv
module uirq_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [1:0]  reg_sel,
    input logic [31:0] reg_wdata,
    input logic [31:0] reg_rdata,
    input logic        irq,
    input logic        line_err,
    input logic        dtr,
    input logic        rx_pop,
    input logic        to_fired,
    input logic [9:0]  mask_q,
    input logic [9:0]  raw_vec
);
    logic run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= 1'b1;
    end

    AST_CAUSE_GAPS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == 2'd1) |-> (reg_rdata[31:26] == 6'd0 && reg_rdata[15:10] == 6'd0)); // R2
    AST_LINE_ERR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        line_err |=> raw_vec[4]); // R5
    AST_HOLD_UNTIL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_vec[4] && !(reg_wr && reg_sel == 2'd1 && (reg_wdata[4] || reg_wdata[20])))
        |=> raw_vec[4]); // R6
    AST_DTR_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && $rose(dtr)) |=> raw_vec[8]); // R7
    AST_DTR_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && $fell(dtr)) |=> raw_vec[9]); // R7
    AST_TIMEOUT_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (to_fired && rx_pop) |=> !raw_vec[3]); // R9
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == 10'd0) |-> !irq); // R10
endmodule

bind uirq_ctrl uirq_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq       (irq),
    .line_err  (line_err),
    .dtr       (dtr),
    .rx_pop    (rx_pop),
    .to_fired  (to_fired),
    .mask_q    (mask_q),
    .raw_vec   (raw_vec)
);

// File: tb/uirq_ctrl_test.sv
`timescale 1ns/1ps
module uirq_ctrl_test;
    localparam int RXW = 6;
    localparam int TXW = 5;
    localparam int TOC = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [RXW-1:0] rx_level = '0;
    logic [TXW-1:0] tx_level = '0;
    logic rx_push = 0, rx_pop = 0, char_tick = 0, modem_chg = 0, line_err = 0;
    logic tx_dma_done = 0, rx_dma_done = 0, rx_dma_to = 0, dtr = 0;
    logic [4:0] flow_level;
    logic irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    uirq_ctrl #(.RX_LVL_W(RXW), .TX_LVL_W(TXW), .TO_CHARS(TOC)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_level(rx_level),
        .tx_level(tx_level), .rx_push(rx_push), .rx_pop(rx_pop),
        .char_tick(char_tick), .modem_chg(modem_chg), .line_err(line_err),
        .tx_dma_done(tx_dma_done), .rx_dma_done(rx_dma_done),
        .rx_dma_to(rx_dma_to), .dtr(dtr), .flow_level(flow_level), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_reg(input logic [1:0] s, input logic [31:0] exp, input string req);
        reg_sel = s;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic strobe(input int ev);
        @(negedge clk);
        case (ev)
            0: modem_chg = 1'b1;
            4: line_err = 1'b1;
            5: tx_dma_done = 1'b1;
            6: rx_dma_done = 1'b1;
            7: rx_dma_to = 1'b1;
            default: ;
        endcase
        @(negedge clk);
        modem_chg = 0; line_err = 0; tx_dma_done = 0; rx_dma_done = 0; rx_dma_to = 0;
    endtask

    task automatic ctick();
        @(negedge clk); char_tick = 1'b1;
        @(negedge clk); char_tick = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: reset state; tx level 0 <= threshold 0 shows event 2 raw
        chk_reg(2'd0, 32'h0, "R1 mask");
        chk_reg(2'd1, 32'h0004_0000, "R1 cause");
        chk_reg(2'd2, 32'h0000_0001, "R1 trigger");
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk_reg(2'd3, 32'h0, "R12 unused select");
        // R11 field positions
        wr(2'd2, 32'hFFFF_FFFF);
        chk_reg(2'd2, 32'h001F_0F1F, "R11 trigger fields");
        chk("R11 flow_level", {27'b0, flow_level}, 32'd31);
        wr(2'd3, 32'hFFFF_FFFF);
        chk_reg(2'd0, 32'h0, "R12 select 3 writes nothing");
        // R3 receive threshold sweep
        tx_level = 5'd1;
        for (int thr = 0; thr < 32; thr++) begin
            wr(2'd2, thr);
            for (int lv = 0; lv <= 32; lv++) begin
                rx_level = lv[RXW-1:0];
                chk_reg(2'd1, (lv >= thr) ? 32'h0002_0000 : 32'h0, "R3 rx available");
            end
        end
        rx_level = '0;
        // R4 transmit threshold sweep
        for (int thr = 0; thr < 16; thr++) begin
            wr(2'd2, (thr << 8) | 1);
            for (int lv = 0; lv < 32; lv++) begin
                tx_level = lv[TXW-1:0];
                chk_reg(2'd1, (lv <= thr) ? 32'h0004_0000 : 32'h0, "R4 tx needed");
            end
        end
        wr(2'd2, 32'h1);
        tx_level = 5'd1;
        // R5 each held strobe sets only its own bit
        foreach (uirq_pkg::HELD_EVENTS[i]) begin
            if (i == 0 || (i >= 4 && i <= 7)) begin
                strobe(i);
                chk_reg(2'd1, 32'h1 << (16 + i), "R5 held event");
                cyc();
                chk_reg(2'd1, 32'h1 << (16 + i), "R5 still held");
                wr(2'd1, 32'h03FF_03FF);
                chk_reg(2'd1, 32'h0, "R6 cleared");
            end
        end
        // R6 clear rules
        strobe(4);
        wr(2'd1, 32'h0);
        chk_reg(2'd1, 32'h0010_0000, "R6 zero write keeps");
        wr(2'd1, 32'h0010_0000);
        chk_reg(2'd1, 32'h0, "R6 upper copy clears");
        strobe(4);
        wr(2'd1, 32'h0000_0010);
        chk_reg(2'd1, 32'h0, "R6 lower copy clears");
        @(negedge clk);
        line_err = 1; reg_sel = 2'd1; reg_wdata = 32'h0010_0010; reg_wr = 1;
        @(negedge clk);
        line_err = 0; reg_wr = 0;
        chk_reg(2'd1, 32'h0010_0000, "R6 set wins over clear");
        wr(2'd1, 32'h0010_0000);
        rx_level = 6'd5;
        wr(2'd1, 32'hFFFF_FFFF);
        chk_reg(2'd1, 32'h0002_0000, "R6 level event not cleared");
        rx_level = '0;
        cyc();
        // R7 DTR edges
        @(negedge clk); dtr = 1'b1;
        cyc();
        chk_reg(2'd1, 32'h0100_0000, "R7 dtr rise");
        cyc();
        chk_reg(2'd1, 32'h0100_0000, "R7 steady high no fall");
        @(negedge clk); dtr = 1'b0;
        cyc();
        chk_reg(2'd1, 32'h0300_0000, "R7 dtr fall");
        wr(2'd1, 32'h0300_0000);
        chk_reg(2'd1, 32'h0, "R7 cleared");
        // R8 timeout firing
        rx_level = 6'd3;
        wr(2'd2, 32'h4);
        cyc();
        for (int k = 0; k < TOC; k++) begin
            ctick();
            chk_reg(2'd1, (k == TOC - 1) ? 32'h0008_0000 : 32'h0, "R8 timeout count");
        end
        // R9 pop clears
        @(negedge clk); rx_pop = 1'b1;
        @(negedge clk); rx_pop = 1'b0;
        chk_reg(2'd1, 32'h0, "R9 pop clears timeout");
        cyc();
        // R8 push restarts the count
        for (int k = 0; k < TOC - 1; k++) ctick();
        @(negedge clk); rx_push = 1'b1;
        @(negedge clk); rx_push = 1'b0;
        for (int k = 0; k < TOC - 1; k++) ctick();
        chk_reg(2'd1, 32'h0, "R8 restart after push");
        ctick();
        chk_reg(2'd1, 32'h0008_0000, "R8 fires after restart");
        @(negedge clk); rx_pop = 1'b1;
        @(negedge clk); rx_pop = 1'b0;
        cyc();
        // R9 empty fifo aborts count
        for (int k = 0; k < TOC - 1; k++) ctick();
        rx_level = '0;
        for (int k = 0; k < TOC; k++) ctick();
        chk_reg(2'd1, 32'h0, "R9 empty aborts timeout");
        // R10 / R2 mask sweep with raw pattern 0x3F3
        strobe(0); strobe(4); strobe(5); strobe(6); strobe(7);
        @(negedge clk); dtr = 1'b1;
        @(negedge clk); dtr = 1'b0;
        cyc();
        rx_level = 6'd5;
        for (int m = 0; m < 1024; m++) begin
            wr(2'd0, m);
            chk_reg(2'd1, {6'b0, 10'h3F3, 6'b0, 10'(m) & 10'h3F3}, "R2 cause layout");
            chk("R10 irq", {31'b0, irq}, {31'b0, |(10'(m) & 10'h3F3)});
        end
        wr(2'd0, 32'h0);
        chk("R10 zero mask", {31'b0, irq}, 32'h0);
        chk_reg(2'd0, 32'h0, "R12 mask readback");
        finished = 1;
        summary();
        $finish;
    end
endmodule